// File: doc/BRIEF.md
# Half-Bridge Cross-Conduction Sequencer

This block controls one half bridge built from a high-side and a low-side switch. Software sets a separate on bit for each side. A PWM-enable bit chooses whether an external PWM input also gates those bits. A global enable from the fault and standby logic can override everything. The block drives two digital gate enables. They are never high together. A side may take over from the opposite side only after the filtered request for it has stayed unchanged, with both gates off, for `DEAD_CYC` clock cycles.

The control is a three-state machine with states IDLE_OFF, HI_ON and LO_ON, plus a guard timer.

- A combinational qualifier reduces the inputs to one request: NONE, HI or LO. Conflicting bits, a low PWM input while PWM is enabled, and a low global enable all reduce to NONE.
- Transition DROP_HI (HI_ON to IDLE_OFF) fires on the first clock edge at which the request is no longer HI. DROP_LO is the same for the low side.
- Transition ARM_HI (IDLE_OFF to HI_ON) fires at once if the high side was the last side used, or if no side has been used since reset.
- Otherwise ARM_HI fires only once the guard timer reports that the HI request has been steady for `DEAD_CYC` edges. ARM_LO mirrors this for the low side.
- There is no direct transition between HI_ON and LO_ON.
- The gate outputs are decoded from the state register, so each output changes one edge after the input that caused it.

Top module: `hb_xcond_seq`

## Requirements
- R1: `hs_gate` and `ls_gate` are never high in the same cycle.
- R2: When `glb_en` is low at a clock edge, both gates are low after that edge and stay low while `glb_en` stays low.
- R3: When `hs_on_bit` and `ls_on_bit` are both 1 at a clock edge, both gates are low after that edge.
- R4: With `pwm_en`=1, a side's gate is high only while its on bit and `pwm_in` are both 1. A low `pwm_in` turns the active gate off at the next edge, and that turn-off counts as a handover for R6.
- R5: With `pwm_en`=0, `pwm_in` has no effect on either gate.
- R6: After a gate falls, the opposite gate rises no earlier than `DEAD_CYC` edges later. If the opposite request is present from the edge where the gate fell, it rises exactly `DEAD_CYC` edges after that edge.
- R7: While waiting in IDLE_OFF, any change of the qualified request restarts the wait. An opposite-side gate rises only at the `DEAD_CYC`-th edge after the last change.
- R8: A request for the side that was last on turns that gate on at the next edge, with no wait.
- R9: After reset, before any side has been on, the first single-side request turns its gate on at the next edge.
- R10: While `rst_n` is low and after reset, both gates are low until a request arrives.
- R11: A gate stays high for as long as its qualified request holds. A request for the other side first drops the active gate at the next edge (through IDLE_OFF) and never raises the other gate in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_on_bit | input | 1 | Software on request for the high-side switch |
| ls_on_bit | input | 1 | Software on request for the low-side switch |
| pwm_en | input | 1 | 1: on bits are ANDed with `pwm_in` |
| pwm_in | input | 1 | External PWM signal |
| glb_en | input | 1 | Global enable; low forces both switches off |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The bench targets these corner cases:

- **Exact handover gap.** A sequencer that counts one edge short would let the opposite switch conduct while the first is still turning off.
- **Restart on a request that reappears mid-wait.** A design that kept counting through the gap would arm the opposite side early.
- **Same-side re-enable after a PWM low.** A design that applied the guard here would stretch every PWM off-time by `DEAD_CYC` cycles. A design that skipped the guard after a PWM-caused turn-off would allow shoot-through when the other side is requested.
- **Simultaneous on bits, `glb_en` dropping while a side is on, and toggling `pwm_in` with PWM disabled.** A faulty design would briefly enable both sides, leave a switch on during a fault, or chop an output that should stay steady.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

    // Qualified side request, also used for the last-used side record
    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_HI   = 2'd1,
        SIDE_LO   = 2'd2
    } side_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE_OFF = 2'd0,
        ST_HI_ON    = 2'd1,
        ST_LO_ON    = 2'd2
    } seq_state_e;

    localparam int unsigned NUM_SIDES = 2;

endpackage

// File: rtl/hb_req_qual.sv
module hb_req_qual
    import hb_seq_pkg::*;
(
    input  logic  hs_on_bit,
    input  logic  ls_on_bit,
    input  logic  pwm_en,
    input  logic  pwm_in,
    input  logic  glb_en,
    output side_e req
);

    logic [NUM_SIDES-1:0] on_bits;
    logic [NUM_SIDES-1:0] qual;
    logic                 pwm_gate;

    assign on_bits  = {ls_on_bit, hs_on_bit};
    assign pwm_gate = pwm_en ? pwm_in : 1'b1;

    // Same gating per side: on bit, PWM window, global enable
    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        assign qual[g] = on_bits[g] & pwm_gate & glb_en;
    end

    // Conflicting requests collapse to NONE
    always_comb begin
        unique case (qual)
            2'b01:   req = SIDE_HI;
            2'b10:   req = SIDE_LO;
            default: req = SIDE_NONE;
        endcase
    end

endmodule

// File: rtl/hb_guard_timer.sv
module hb_guard_timer
    import hb_seq_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold_clr,
    input  side_e req,
    output logic  settled
);

    localparam int unsigned CNT_W = $clog2(DEAD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEAD_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEAD_CYC - 1);

    logic [CNT_W-1:0] cnt;
    side_e            req_q;
    logic             req_chg;

    assign req_chg = (req != req_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= SIDE_NONE;
        end else begin
            req_q <= req;
        end
    end

    // Counts edges with an unchanged request while both switches are off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold_clr || req_chg) begin
            cnt <= '0;
        end else if (cnt < CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign settled = !req_chg && (cnt >= CNT_LAST);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);

    // R7
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_chg |=> (cnt == '0));

endmodule

// File: rtl/hb_seq_fsm.sv
module hb_seq_fsm
    import hb_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  side_e req,
    input  logic  settled,
    output logic  on_state,
    output logic  hs_gate,
    output logic  ls_gate
);

    seq_state_e state, state_nxt;
    side_e      last_side, last_nxt;
    logic       arm_hi, arm_lo;

    // Arm a side at once if it was the last one used, else after the guard
    assign arm_hi = (req == SIDE_HI) &&
                    ((last_side != SIDE_LO) || settled);
    assign arm_lo = (req == SIDE_LO) &&
                    ((last_side != SIDE_HI) || settled);

    always_comb begin
        state_nxt = state;
        last_nxt  = last_side;
        unique case (state)
            ST_IDLE_OFF: begin
                if (arm_hi) begin
                    state_nxt = ST_HI_ON;       // ARM_HI
                    last_nxt  = SIDE_HI;
                end else if (arm_lo) begin
                    state_nxt = ST_LO_ON;       // ARM_LO
                    last_nxt  = SIDE_LO;
                end
            end
            ST_HI_ON: begin
                if (req != SIDE_HI) state_nxt = ST_IDLE_OFF;   // DROP_HI
            end
            ST_LO_ON: begin
                if (req != SIDE_LO) state_nxt = ST_IDLE_OFF;   // DROP_LO
            end
            default: state_nxt = ST_IDLE_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE_OFF;
            last_side <= SIDE_NONE;
        end else begin
            state     <= state_nxt;
            last_side <= last_nxt;
        end
    end

    // Output decode
    always_comb begin
        hs_gate  = 1'b0;
        ls_gate  = 1'b0;
        on_state = 1'b0;
        unique case (state)
            ST_HI_ON: begin
                hs_gate  = 1'b1;
                on_state = 1'b1;
            end
            ST_LO_ON: begin
                ls_gate  = 1'b1;
                on_state = 1'b1;
            end
            default: ;
        endcase
    end

    // R11
    no_swap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI_ON) |=> (state != ST_LO_ON));

    // R11
    no_swap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LO_ON) |=> (state != ST_HI_ON));

    // R8
    same_side_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE_OFF && req == SIDE_HI && last_side == SIDE_HI)
            |=> (state == ST_HI_ON));

endmodule

// File: rtl/hb_xcond_seq.sv
module hb_xcond_seq
    import hb_seq_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_on_bit,
    input  logic ls_on_bit,
    input  logic pwm_en,
    input  logic pwm_in,
    input  logic glb_en,
    output logic hs_gate,
    output logic ls_gate
);

    localparam int unsigned GAP_W = $clog2(DEAD_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(DEAD_CYC);

    side_e req;
    logic  settled;
    logic  on_state;

    hb_req_qual u_qual (
        .hs_on_bit (hs_on_bit),
        .ls_on_bit (ls_on_bit),
        .pwm_en    (pwm_en),
        .pwm_in    (pwm_in),
        .glb_en    (glb_en),
        .req       (req)
    );

    hb_guard_timer #(
        .DEAD_CYC (DEAD_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_clr (on_state),
        .req      (req),
        .settled  (settled)
    );

    hb_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .settled  (settled),
        .on_state (on_state),
        .hs_gate  (hs_gate),
        .ls_gate  (ls_gate)
    );

    // Off-time counters observed at the gate outputs, for the gap check
    logic [GAP_W-1:0] hi_off_cnt, lo_off_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_off_cnt <= GAP_MAX;
            lo_off_cnt <= GAP_MAX;
        end else begin
            if (hs_gate)                 hi_off_cnt <= '0;
            else if (hi_off_cnt < GAP_MAX) hi_off_cnt <= hi_off_cnt + 1'b1;
            if (ls_gate)                 lo_off_cnt <= '0;
            else if (lo_off_cnt < GAP_MAX) lo_off_cnt <= lo_off_cnt + 1'b1;
        end
    end

    // R1
    both_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    // R2
    glb_low_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> (!hs_gate && !ls_gate));

    // R3
    both_bits_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on_bit && ls_on_bit) |=> (!hs_gate && !ls_gate));

    // R4
    pwm_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && !pwm_in) |=> (!hs_gate && !ls_gate));

    // R6
    dead_gap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> (hi_off_cnt >= GAP_MAX));

    // R6
    dead_gap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> (lo_off_cnt >= GAP_MAX));

endmodule

// File: tb/hb_xcond_seq_tb_top.sv
module hb_xcond_seq_tb_top;

    localparam int unsigned TB_DEAD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_on_bit = 1'b0, ls_on_bit = 1'b0;
    logic pwm_en = 1'b0, pwm_in = 1'b0, glb_en = 1'b1;
    logic hs_gate, ls_gate;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Scoreboard queues: expected {hs,ls} and the requirement tag
    logic [1:0] exp_q[$];
    string      tag_q[$];

    // Reference model state: 0 none, 1 high side, 2 low side
    int m_on = 0, m_last = 0, m_prev = 0, m_wait = 0;

    always #4 clk = ~clk;   // 125 MHz

    hb_xcond_seq #(.DEAD_CYC(TB_DEAD)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_on_bit (hs_on_bit),
        .ls_on_bit (ls_on_bit),
        .pwm_en    (pwm_en),
        .pwm_in    (pwm_in),
        .glb_en    (glb_en),
        .hs_gate   (hs_gate),
        .ls_gate   (ls_gate)
    );

    function automatic int qual_req(logic h, logic l, logic pe, logic pw, logic ge);
        logic w;
        w = pe ? pw : 1'b1;
        if (!ge || !w) return 0;
        if (h && !l) return 1;
        if (l && !h) return 2;
        return 0;
    endfunction

    // Model of one clock edge, written from R3..R11
    task automatic model_edge(int r);
        int  nxt;
        bit  ok;
        if (m_on == 0) begin
            ok  = (r == m_last) || (m_last == 0) ||
                  ((r == m_prev) && (m_wait >= TB_DEAD - 1));
            nxt = (r != 0 && ok) ? r : 0;
            if (r != m_prev) m_wait = 0;
            else if (m_wait < TB_DEAD) m_wait++;
        end else begin
            nxt    = (r == m_on) ? m_on : 0;
            m_wait = 0;
        end
        if (nxt != 0) m_last = nxt;
        m_prev = r;
        m_on   = nxt;
    endtask

    task automatic drive(logic h, logic l, logic pe, logic pw, logic ge, string tag);
        @(negedge clk);
        hs_on_bit = h; ls_on_bit = l; pwm_en = pe; pwm_in = pw; glb_en = ge;
        model_edge(qual_req(h, l, pe, pw, ge));
        exp_q.push_back({m_on == 1, m_on == 2});
        tag_q.push_back(tag);
    endtask

    task automatic hold(int n, logic h, logic l, logic pe, logic pw, logic ge, string tag);
        for (int i = 0; i < n; i++) drive(h, l, pe, pw, ge, tag);
    endtask

    // Monitor: compare after each edge, plus port-level gap check
    int hi_off = 1000, lo_off = 1000;
    logic prev_hs = 1'b0, prev_ls = 1'b0;

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                vectors++;
                if ({hs_gate, ls_gate} !== e) begin
                    miscompares++;
                    $display("FAIL %s: gates hs/ls got %b%b expected %b%b at %0t",
                             t, hs_gate, ls_gate, e[1], e[0], $time);
                end
                vectors++;
                if (hs_gate && ls_gate) begin
                    miscompares++;
                    $display("FAIL R1: gates hs/ls got 11 expected not both high");
                end
                if (ls_gate && !prev_ls) begin
                    vectors++;
                    if (hi_off < TB_DEAD) begin
                        miscompares++;
                        $display("FAIL R6: high-side off gap got %0d expected >= %0d",
                                 hi_off, TB_DEAD);
                    end
                end
                if (hs_gate && !prev_hs) begin
                    vectors++;
                    if (lo_off < TB_DEAD) begin
                        miscompares++;
                        $display("FAIL R6: low-side off gap got %0d expected >= %0d",
                                 lo_off, TB_DEAD);
                    end
                end
            end
            hi_off  = hs_gate ? 0 : hi_off + 1;
            lo_off  = ls_gate ? 0 : lo_off + 1;
            prev_hs = hs_gate;
            prev_ls = ls_gate;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run got no end expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R10: reset state, inputs requesting the high side during reset
        hs_on_bit = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        vectors++;
        if (hs_gate !== 1'b0 || ls_gate !== 1'b0) begin
            miscompares++;
            $display("FAIL R10: gates in reset got %b%b expected 00", hs_gate, ls_gate);
        end
        @(negedge clk);
        hs_on_bit = 1'b0;
        rst_n = 1'b1;
        hold(3, 0, 0, 0, 0, 1, "R10");

        // R9: first request, no wait
        hold(1, 1, 0, 0, 0, 1, "R9");
        hold(4, 1, 0, 0, 0, 1, "R11");
        // R6/R11: handover high -> low, exact gap
        hold(TB_DEAD + 4, 0, 1, 0, 0, 1, "R6");
        // R8: drop low side one cycle and re-request
        hold(1, 0, 0, 0, 0, 1, "R8");
        hold(3, 0, 1, 0, 0, 1, "R8");
        // R7: opposite request interrupted mid-wait restarts the guard
        hold(3, 1, 0, 0, 0, 1, "R7");
        hold(1, 0, 0, 0, 0, 1, "R7");
        hold(TB_DEAD + 3, 1, 0, 0, 0, 1, "R7");
        // R7: request flips between sides during the wait
        hold(2, 0, 1, 0, 0, 1, "R7");
        hold(2, 1, 0, 0, 0, 1, "R7");
        hold(TB_DEAD + 2, 0, 1, 0, 0, 1, "R7");
        // R3: both bits set while low side is on
        hold(5, 1, 1, 0, 0, 1, "R3");
        hold(3, 0, 1, 0, 0, 1, "R3");
        hold(TB_DEAD + 2, 1, 1, 0, 1, 1, "R3");
        // R4: PWM gating on the low side
        hold(2, 0, 1, 1, 1, 1, "R4");
        hold(2, 0, 1, 1, 0, 1, "R4");
        hold(2, 0, 1, 1, 1, 1, "R4");
        // R4: PWM-caused turn-off then opposite request must wait
        hold(1, 0, 1, 1, 0, 1, "R4");
        hold(TB_DEAD + 3, 1, 0, 1, 1, 1, "R4");
        // R5: PWM disabled, toggling pwm_in has no effect
        for (int i = 0; i < 8; i++) drive(1, 0, 0, i[0], 1, "R5");
        // R2: global enable low while high side is on
        hold(4, 1, 0, 0, 0, 0, "R2");
        hold(2, 0, 1, 0, 0, 0, "R2");
        hold(TB_DEAD + 3, 0, 1, 0, 0, 1, "R2");
        // R1: random stimulus
        for (int i = 0; i < 400; i++) begin
            int unsigned rv;
            rv = $urandom;
            drive(rv[0], rv[1], rv[2], rv[3] | rv[4], (rv[7:5] != 3'd0), "R1");
        end
        hold(3, 0, 0, 0, 0, 1, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule